// File: doc/BRIEF.md
# Column Binary Line Transposer

This block turns a print line held in row order into column order. The line is kept in an external buffer as 12 rows of 72 bits. Each row occupies two 36-bit words. The transposer reads that buffer through a synchronous read port and emits, from left to right, one 12-bit code per column. Each code collects the bit that every row holds at that column.

A one-cycle pulse on `start` begins a conversion. The block fetches one buffer word per clock, so a column code appears every 12 cycles, together with its column index. After the last column it pulses `done` and reports the trimmed length, which is the position just past the rightmost column that has any bit set. A downstream formatter can use that length to drop trailing blanks from its 80-position line, because positions 72 to 79 never hold data. Mapping the codes to characters is left to that formatter.

Top module: `colbin_transposer`

## Requirements
- R1: After reset, `col_vld` and `done` are low and `trim_len` is 0, and they stay that way until a start is accepted.
- R2: One conversion emits exactly 72 column codes, with `col_idx` running 0, 1, ... 71 in that order.
- R3: The code bit for row r at column c is read from buffer word 2r + (c / 36). The word is fetched by driving `rd_addr`, and `rd_data` returns it one clock later.
- R4: Inside a word, column c uses bit 35 - (c mod 36), so the leftmost column of each half is the word's most significant bit.
- R5: Bit r of `col_code` is the bit that row r holds at that column. Bit 0 is row 0, which is words 0 and 1.
- R6: If a start is sampled at clock edge E0, the code for column c is valid after edge E0+13+12c and is high for one cycle only.
- R7: `done` is a one-cycle pulse that rises on the edge after the one that presents column 71, which is E0+866.
- R8: When `done` is high, `trim_len` equals one plus the index of the rightmost column whose code is nonzero, or 0 if every code is zero. An all-zero code counts as blank. The value never exceeds 72.
- R9: A start that arrives between the accepting edge and the edge that raises `done` is ignored. The running conversion's timing and output are unchanged, and no extra columns follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion (ignored while one runs) |
| rd_addr | output | 5 | Buffer word address |
| rd_data | input | 36 | Buffer word, one cycle after `rd_addr` |
| col_vld | output | 1 | `col_code` and `col_idx` are valid |
| col_code | output | 12 | Column code, bit r = row r |
| col_idx | output | 7 | Column index 0..71 |
| done | output | 1 | One-cycle end-of-line pulse |
| trim_len | output | 7 | Trimmed line length, valid with `done` |

## Verification
An all-zero buffer and an all-ones buffer test the two extremes of every code and of the trimmed length (0 and 72). An arithmetic hash pattern gives each word distinct contents. Against it, the expected codes catch a swapped word half, a reversed bit order or a misplaced row bit. Single-bit buffers at column 0, at column 71 and across the 35/36 word boundary pin down the trimmed length and the word-half selection, with the issue cycle of each code checked against its column. A start pulsed in the middle of the hash run shows that the running line keeps its timing and its 72 columns.

// File: rtl/colbin_pkg.sv
package colbin_pkg;
  localparam int unsigned DEF_ROWS   = 12;
  localparam int unsigned DEF_WORD_W = 36;
  localparam int unsigned DEF_HALVES = 2;
endpackage

// File: rtl/colbin_fetch.sv
module colbin_fetch #(
  parameter int unsigned ROWS   = 12,
  parameter int unsigned WORD_W = 36,
  parameter int unsigned HALVES = 2,
  localparam int unsigned RW = $clog2(ROWS),
  localparam int unsigned LW = $clog2(WORD_W),
  localparam int unsigned HW = (HALVES > 1) ? $clog2(HALVES) : 1,
  localparam int unsigned AW = $clog2(ROWS * HALVES),
  localparam int unsigned CW = $clog2(WORD_W * HALVES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  output logic [AW-1:0] rd_addr,
  output logic          tag_vld,
  output logic [RW-1:0] tag_row,
  output logic [LW-1:0] tag_bit,
  output logic [CW-1:0] tag_col
);
  logic          act_q;
  logic [RW-1:0] row_q;
  logic [LW-1:0] lo_q;
  logic [HW-1:0] half_q;

  assign rd_addr = AW'(row_q) * AW'(HALVES) + AW'(half_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      row_q  <= '0;
      lo_q   <= '0;
      half_q <= '0;
    end else if (go) begin
      act_q  <= 1'b1;
      row_q  <= '0;
      lo_q   <= '0;
      half_q <= '0;
    end else if (act_q) begin
      if (row_q == RW'(ROWS - 1)) begin
        row_q <= '0;
        if (lo_q == LW'(WORD_W - 1)) begin
          lo_q <= '0;
          if (half_q == HW'(HALVES - 1)) act_q <= 1'b0;
          else half_q <= half_q + 1'b1;
        end else begin
          lo_q <= lo_q + 1'b1;
        end
      end else begin
        row_q <= row_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_vld <= 1'b0;
      tag_row <= '0;
      tag_bit <= '0;
      tag_col <= '0;
    end else begin
      tag_vld <= act_q;
      tag_row <= row_q;
      tag_bit <= lo_q;
      tag_col <= CW'(half_q) * CW'(WORD_W) + CW'(lo_q);
    end
  end

  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    act_q |-> (rd_addr < AW'(ROWS * HALVES)));
endmodule

// File: rtl/colbin_gather.sv
module colbin_gather #(
  parameter int unsigned ROWS   = 12,
  parameter int unsigned WORD_W = 36,
  parameter int unsigned HALVES = 2,
  localparam int unsigned RW = $clog2(ROWS),
  localparam int unsigned LW = $clog2(WORD_W),
  localparam int unsigned CW = $clog2(WORD_W * HALVES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tag_vld,
  input  logic [RW-1:0]     tag_row,
  input  logic [LW-1:0]     tag_bit,
  input  logic [CW-1:0]     tag_col,
  input  logic [WORD_W-1:0] rd_data,
  output logic              col_vld,
  output logic [ROWS-1:0]   col_code,
  output logic [CW-1:0]     col_idx
);
  logic [ROWS-1:0] acc_q, acc_d;
  logic            pick;

  always_comb begin
    pick  = rd_data[LW'(WORD_W - 1) - tag_bit];
    acc_d = (tag_row == '0) ? '0 : acc_q;
    acc_d[tag_row] = pick;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      col_vld  <= 1'b0;
      col_code <= '0;
      col_idx  <= '0;
    end else begin
      col_vld <= 1'b0;
      if (tag_vld) begin
        acc_q <= acc_d;
        if (tag_row == RW'(ROWS - 1)) begin
          col_vld  <= 1'b1;
          col_code <= acc_d;
          col_idx  <= tag_col;
        end
      end
    end
  end

  logic [CW-1:0] seen_idx_q;
  always_ff @(posedge clk) begin
    if (rst) seen_idx_q <= '0;
    else if (col_vld) seen_idx_q <= col_idx;
  end

  // R6
  col_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    col_vld |=> !col_vld);

  // R2
  col_order_chk: assert property (@(posedge clk) disable iff (rst)
    (col_vld && col_idx != '0) |-> (col_idx == seen_idx_q + 1'b1));
endmodule

// File: rtl/colbin_trim.sv
module colbin_trim #(
  parameter int unsigned ROWS = 12,
  parameter int unsigned COLS = 72,
  localparam int unsigned CW = $clog2(COLS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            col_vld,
  input  logic [ROWS-1:0] col_code,
  input  logic [CW-1:0]   col_idx,
  output logic            done,
  output logic [CW-1:0]   trim_len
);
  logic [CW-1:0] last_q;
  logic          marked;
  logic          final_col;

  assign marked    = col_vld && (col_code != '0);
  assign final_col = col_vld && (col_idx == CW'(COLS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q   <= '0;
      done     <= 1'b0;
      trim_len <= '0;
    end else begin
      done <= final_col;
      if (clear) last_q <= '0;
      else if (marked) last_q <= col_idx + 1'b1;
      if (final_col) trim_len <= marked ? col_idx + 1'b1 : last_q;
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  trim_range_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (trim_len <= CW'(COLS)));
endmodule

// File: rtl/colbin_transposer.sv
module colbin_transposer
  import colbin_pkg::*;
#(
  parameter int unsigned ROWS   = DEF_ROWS,
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned HALVES = DEF_HALVES,
  localparam int unsigned COLS = WORD_W * HALVES,
  localparam int unsigned RW = $clog2(ROWS),
  localparam int unsigned LW = $clog2(WORD_W),
  localparam int unsigned AW = $clog2(ROWS * HALVES),
  localparam int unsigned CW = $clog2(COLS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [AW-1:0]     rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              col_vld,
  output logic [ROWS-1:0]   col_code,
  output logic [CW-1:0]     col_idx,
  output logic              done,
  output logic [CW-1:0]     trim_len
);
  logic          running_q;
  logic          go;
  logic          tag_vld;
  logic [RW-1:0] tag_row;
  logic [LW-1:0] tag_bit;
  logic [CW-1:0] tag_col;

  assign go = start && !running_q;

  always_ff @(posedge clk) begin
    if (rst) running_q <= 1'b0;
    else if (go) running_q <= 1'b1;
    else if (col_vld && col_idx == CW'(COLS - 1)) running_q <= 1'b0;
  end

  colbin_fetch #(.ROWS(ROWS), .WORD_W(WORD_W), .HALVES(HALVES)) u_fetch (
    .clk(clk), .rst(rst), .go(go), .rd_addr(rd_addr),
    .tag_vld(tag_vld), .tag_row(tag_row), .tag_bit(tag_bit), .tag_col(tag_col)
  );

  colbin_gather #(.ROWS(ROWS), .WORD_W(WORD_W), .HALVES(HALVES)) u_gather (
    .clk(clk), .rst(rst), .tag_vld(tag_vld), .tag_row(tag_row),
    .tag_bit(tag_bit), .tag_col(tag_col), .rd_data(rd_data),
    .col_vld(col_vld), .col_code(col_code), .col_idx(col_idx)
  );

  colbin_trim #(.ROWS(ROWS), .COLS(COLS)) u_trim (
    .clk(clk), .rst(rst), .clear(go), .col_vld(col_vld),
    .col_code(col_code), .col_idx(col_idx), .done(done), .trim_len(trim_len)
  );

  // R9
  busy_output_chk: assert property (@(posedge clk) disable iff (rst)
    (col_vld || done) |-> (running_q || done));
endmodule

// File: tb/sim_colbin_transposer.sv
module sim_colbin_transposer;
  localparam int PERIOD = 10;
  localparam int NROWS  = 12;
  localparam int NCOLS  = 72;
  localparam int NWORDS = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  rd_addr;
  logic [35:0] rd_data;
  logic        col_vld;
  logic [11:0] col_code;
  logic [6:0]  col_idx;
  logic        done;
  logic [6:0]  trim_len;

  logic [35:0] mem [NWORDS];
  int checks = 0;
  int errors = 0;

  always #(PERIOD / 2) clk = ~clk;
  always @(posedge clk) rd_data <= mem[rd_addr];

  colbin_transposer u0 (
    .clk(clk), .rst(rst), .start(start), .rd_addr(rd_addr), .rd_data(rd_data),
    .col_vld(col_vld), .col_code(col_code), .col_idx(col_idx),
    .done(done), .trim_len(trim_len)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(PERIOD / 4);
  endtask

  function automatic logic [11:0] exp_code(input int c);
    logic [11:0] v = '0;
    for (int r = 0; r < NROWS; r++)
      v[r] = mem[2 * r + c / 36][35 - (c % 36)];
    return v;
  endfunction

  function automatic int exp_trim();
    int t = 0;
    for (int c = 0; c < NCOLS; c++)
      if (exp_code(c) != 0) t = c + 1;
    return t;
  endfunction

  task automatic fill(input int kind);
    for (int w = 0; w < NWORDS; w++) begin
      case (kind)
        0: mem[w] = '0;
        1: mem[w] = '1;
        default: mem[w] = 36'(64'h9E3779B97F4A7C15 * longint'(w + 7)) ^ 36'(w * w * 1237);
      endcase
    end
  endtask

  task automatic run_line(input string tag, input bit poke);
    int n = 0;
    int exp_idx = 0;
    int dones = 0;
    int want_trim = exp_trim();
    start = 1'b1;
    tick();
    start = 1'b0;
    while (dones == 0 && n < 2000) begin
      tick();
      n++;
      if (poke) start = (n == 100) || (n == 500);
      if (col_vld) begin
        chk(n == 13 + 12 * exp_idx, {"R6 issue cycle ", tag}, n, 13 + 12 * exp_idx);
        chk(col_idx == 7'(exp_idx), {"R2 column index ", tag}, col_idx, exp_idx);
        chk(col_code == exp_code(exp_idx), {"R3 R4 R5 column code ", tag},
            col_code, exp_code(exp_idx));
        exp_idx++;
      end
      if (done) begin
        dones++;
        chk(n == 866, {"R7 done cycle ", tag}, n, 866);
        chk(exp_idx == NCOLS, {"R2 column count ", tag}, exp_idx, NCOLS);
        chk(trim_len == 7'(want_trim), {"R8 trimmed length ", tag}, trim_len, want_trim);
      end
    end
    start = 1'b0;
    chk(dones == 1, {"R7 done seen ", tag}, dones, 1);
    tick();
    chk(!done, {"R7 done single cycle ", tag}, done, 0);
    for (int k = 0; k < 30; k++) begin
      tick();
      if (col_vld || done) begin
        chk(1'b0, {"R9 extra output after line ", tag}, 1, 0);
        break;
      end
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    fill(0);
    repeat (3) tick();
    rst = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk(!col_vld && !done && trim_len == 0, "R1 reset state",
          {col_vld, done, trim_len}, 0);
    end

    fill(0);
    run_line("zeros", 1'b0);
    fill(1);
    run_line("ones", 1'b0);
    fill(2);
    run_line("hash", 1'b0);
    run_line("hash with stray start R9", 1'b1);

    fill(0);
    mem[0][35] = 1'b1;
    run_line("col0 row0", 1'b0);

    fill(0);
    mem[23][0] = 1'b1;
    run_line("col71 row11", 1'b0);

    fill(0);
    mem[10][0] = 1'b1;
    mem[13][35] = 1'b1;
    run_line("halves boundary", 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule